// File: doc/BRIEF.md
# First/Next Error Status Logger

This block gathers error events from two places and keeps them in status registers that software can read. The first is the graphics-port request path. The second is the address-translation path. Each path has a pair of 8-bit registers. The "first" register catches the earliest error, or errors, seen while it reads zero, and then holds that value. The "next" register collects every later error except the conditions already held in the "first" register. Software reads the registers through a plain register port and clears bits by writing ones to them.

Some of the error conditions are detected inside the block:
- an outstanding-request counter that flags a new request arriving while the queue is full;
- a check that the upper address bits of a request are zero;
- a check for a pipelined request made while sideband addressing is on;
- a decoder that flags an illegal translated address.

Parity faults and translation-entry faults come in as single-cycle strobes from the logic that detects them. No data streams through the block, so every pin is plain control or status and has no back-pressure.

Top module: `err_status_logger`

## Requirements
- R1: While a "first" register reads zero, every valid error bit that fires in a cycle is latched into it at the next clock edge, all together. The "next" register of that path gains no bits in that cycle.
- R2: While a "first" register is nonzero, new errors never add bits to it.
- R3: While a "first" register is nonzero, each error that fires sets its bit in the "next" register, unless that bit is currently set in "first".
- R4: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. If a write clears a bit in the same cycle that its error fires again, the bit stays set.
- R5: Once software has cleared a "first" register to zero, the next error latches into it again.
- R6: Reserved bits always read zero and cannot be set by errors or writes. In the request registers, bits 7:6 are reserved. In the translation registers, bits 0 and 7:4 are reserved.
- R7: The request-register bits are:
  - bit 0: a request (`req_valid`) carrying an illegal command;
  - bit 2: a request with any of address bits [63:40] set;
  - bit 3: a request with `req_pipe` while `sideband_en` is high;
  - bit 4: a high-priority read-queue parity strobe;
  - bit 5: a low-priority read-queue parity strobe.
- R8: At most 16 requests may be outstanding. `req_done` retires one request. A request that arrives while 16 are outstanding sets request bit 1 and is not counted. Requests up to the 16th set nothing.
- R9: Translation bit 1 is set by a valid translation whose address meets any of these conditions:
  - it lies in the inclusive window from `ap_base` to `ap_top`;
  - it lies in A0000h–BFFFFh while `vga_en` is high;
  - it is routed to PCI;
  - it is above `mem_top`.
  Bit 2 is set by the entry-invalid strobe and bit 3 by the table-parity strobe.
- R10: The status registers are sticky. `soft_rst_n` leaves them unchanged but empties the request counter. `por_n` clears everything.
- R11: Register address 0 selects the request "first" register, 1 the request "next", 2 the translation "first" and 3 the translation "next". Read data is combinational from the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| soft_rst_n | input | 1 | Soft reset, active low; clears only the request counter |
| req_valid | input | 1 | A new request arrives this cycle |
| req_done | input | 1 | One outstanding request retires this cycle |
| req_cmd_bad | input | 1 | The arriving request carries an illegal command |
| req_pipe | input | 1 | The arriving request uses pipelined addressing |
| sideband_en | input | 1 | Sideband addressing is enabled |
| req_addr | input | ADDR_W | Address of the arriving request |
| rdq_hi_par_err | input | 1 | Parity strobe for the high-priority read queue |
| rdq_lo_par_err | input | 1 | Parity strobe for the low-priority read queue |
| xl_valid | input | 1 | A translated address is presented this cycle |
| xl_addr | input | XA_W | Translated address |
| ap_base | input | XA_W | Aperture window base, inclusive |
| ap_top | input | XA_W | Aperture window top, inclusive |
| vga_en | input | 1 | The legacy VGA range is claimed |
| xl_to_pci | input | 1 | The translation is routed to PCI, not memory |
| mem_top | input | XA_W | Highest legal memory address |
| xl_entry_invalid | input | 1 | Strobe: the translation entry is invalid |
| xl_par_err | input | 1 | Strobe: translation table parity fault |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe; the written ones clear bits |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |

## Verification
A wrong internal state shows up at the read port one clock after the event that should have caused it. An error latched into the wrong tier, or a lock that fails to hold, changes the value read back right away. A miscounted queue appears only at the boundary: the overflow bit is set at the wrong request, either too early or too late. The bench therefore sweeps pairs of error bits, every bit position of the upper address, and a grid of translated addresses against each condition flag. After every stimulus it compares both registers with values computed from bit positions.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned NPATH  = 2;

  // request-path bit positions
  localparam int unsigned RQ_CMD   = 0;
  localparam int unsigned RQ_OVF   = 1;
  localparam int unsigned RQ_UPPER = 2;
  localparam int unsigned RQ_PIPE  = 3;
  localparam int unsigned RQ_HIPAR = 4;
  localparam int unsigned RQ_LOPAR = 5;
  localparam logic [STAT_W-1:0] RQ_MASK = 8'h3F;

  // translation-path bit positions
  localparam int unsigned XL_ILLEGAL = 1;
  localparam int unsigned XL_INVALID = 2;
  localparam int unsigned XL_PARITY  = 3;
  localparam logic [STAT_W-1:0] XL_MASK = 8'h0E;

  typedef enum logic [1:0] {
    SEL_RQ_FIRST = 2'd0,
    SEL_RQ_NEXT  = 2'd1,
    SEL_XL_FIRST = 2'd2,
    SEL_XL_NEXT  = 2'd3
  } reg_sel_e;

  function automatic logic [STAT_W-1:0] path_mask(input int unsigned p);
    return (p == 0) ? RQ_MASK : XL_MASK;
  endfunction
endpackage

// File: rtl/err_req_checks.sv
module err_req_checks
  import err_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned HI_LSB = 40,
  parameter int unsigned QDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_done,
  input  logic              req_cmd_bad,
  input  logic              req_pipe,
  input  logic              sideband_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hi_par,
  input  logic              lo_par,
  output logic [STAT_W-1:0] ev
);
  localparam int unsigned CNT_W = $clog2(QDEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(QDEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic accept, overflow, retire, upper_bad;

  generate
    if (ADDR_W > HI_LSB) begin : g_upper
      assign upper_bad = |req_addr[ADDR_W-1:HI_LSB];
    end else begin : g_no_upper
      assign upper_bad = 1'b0;
    end
  endgenerate

  assign accept   = req_valid && (cnt_q != FULL);
  assign overflow = req_valid && (cnt_q == FULL);
  assign retire   = req_done && ((cnt_q != '0) || accept);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(retire);
  end

  always_comb begin
    ev           = '0;
    ev[RQ_CMD]   = req_valid && req_cmd_bad;
    ev[RQ_OVF]   = overflow;
    ev[RQ_UPPER] = req_valid && upper_bad;
    ev[RQ_PIPE]  = req_valid && req_pipe && sideband_en;
    ev[RQ_HIPAR] = hi_par;
    ev[RQ_LOPAR] = lo_par;
  end

  // R8: the counter never passes the queue depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R8: a request into a full queue leaves the count unchanged unless one retires
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && req_valid && !req_done) |=> (cnt_q == FULL));
  // R8: below full, no overflow event
  p_no_false_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < FULL) |-> !ev[RQ_OVF]);
endmodule

// File: rtl/err_xlat_checks.sv
module err_xlat_checks
  import err_log_pkg::*;
#(
  parameter int unsigned XA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  input  logic [XA_W-1:0]   xl_addr,
  input  logic [XA_W-1:0]   ap_base,
  input  logic [XA_W-1:0]   ap_top,
  input  logic              vga_en,
  input  logic              xl_to_pci,
  input  logic [XA_W-1:0]   mem_top,
  input  logic              entry_invalid,
  input  logic              par_err,
  output logic [STAT_W-1:0] ev
);
  localparam logic [XA_W-1:0] VGA_LO = XA_W'(20'hA0000);
  localparam logic [XA_W-1:0] VGA_HI = XA_W'(20'hBFFFF);

  logic in_aperture, in_vga, above_mem, illegal;

  assign in_aperture = (xl_addr >= ap_base) && (xl_addr <= ap_top);
  assign in_vga      = vga_en && (xl_addr >= VGA_LO) && (xl_addr <= VGA_HI);
  assign above_mem   = xl_addr > mem_top;
  assign illegal     = in_aperture || in_vga || xl_to_pci || above_mem;

  always_comb begin
    ev             = '0;
    ev[XL_ILLEGAL] = xl_valid && illegal;
    ev[XL_INVALID] = entry_invalid;
    ev[XL_PARITY]  = par_err;
  end

  // R9: a PCI-routed translation is always illegal
  p_pci_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_to_pci) |-> ev[XL_ILLEGAL]);
  // R9: no illegal flag without a valid translation
  p_idle_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |-> !ev[XL_ILLEGAL]);
endmodule

// File: rtl/err_tier_log.sv
module err_tier_log
  import err_log_pkg::*;
#(
  parameter logic [STAT_W-1:0] VALID_MASK = 8'hFF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [STAT_W-1:0] ev,
  input  logic [STAT_W-1:0] clr_first,
  input  logic [STAT_W-1:0] clr_next,
  output logic [STAT_W-1:0] first_q,
  output logic [STAT_W-1:0] next_q
);
  logic [STAT_W-1:0] e, cf, cn, first_d, next_d;

  assign e  = ev & VALID_MASK;
  assign cf = clr_first & VALID_MASK;
  assign cn = clr_next & VALID_MASK;

  always_comb begin
    if (first_q == '0) begin
      first_d = e;
      next_d  = next_q & ~cn;
    end else begin
      first_d = (first_q & ~cf) | (first_q & e);
      next_d  = (next_q & ~cn) | (e & ~first_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else begin
      first_q <= first_d;
      next_q  <= next_d;
    end
  end

  // R6: reserved bits stay zero
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!por_n)
    ((first_q | next_q) & ~VALID_MASK) == '0);
  // R2: a held first register gains no bits
  p_first_locked_r2: assert property (@(posedge clk) disable iff (!por_n)
    (first_q != '0) |=> ((first_q & ~$past(first_q)) == '0));
  // R3: bits held in first are not newly set in next
  p_next_excl_r3: assert property (@(posedge clk) disable iff (!por_n)
    (first_q != '0) |=> ((next_q & ~$past(next_q) & $past(first_q)) == '0));
  // R1: while first is empty, next only holds or clears
  p_next_quiet_r1: assert property (@(posedge clk) disable iff (!por_n)
    (first_q == '0 && clr_next == '0) |=> $stable(next_q));
endmodule

// File: rtl/err_status_logger.sv
module err_status_logger
  import err_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned HI_LSB = 40,
  parameter int unsigned QDEPTH = 16,
  parameter int unsigned XA_W   = 40
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              req_valid,
  input  logic              req_done,
  input  logic              req_cmd_bad,
  input  logic              req_pipe,
  input  logic              sideband_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rdq_hi_par_err,
  input  logic              rdq_lo_par_err,
  input  logic              xl_valid,
  input  logic [XA_W-1:0]   xl_addr,
  input  logic [XA_W-1:0]   ap_base,
  input  logic [XA_W-1:0]   ap_top,
  input  logic              vga_en,
  input  logic              xl_to_pci,
  input  logic [XA_W-1:0]   mem_top,
  input  logic              xl_entry_invalid,
  input  logic              xl_par_err,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic q_rst_n;
  logic [STAT_W-1:0] ev     [NPATH];
  logic [STAT_W-1:0] clr_f  [NPATH];
  logic [STAT_W-1:0] clr_n  [NPATH];
  logic [STAT_W-1:0] first  [NPATH];
  logic [STAT_W-1:0] next   [NPATH];

  assign q_rst_n = por_n && soft_rst_n;

  err_req_checks #(.ADDR_W(ADDR_W), .HI_LSB(HI_LSB), .QDEPTH(QDEPTH)) u_req (
    .clk(clk), .rst_n(q_rst_n), .req_valid(req_valid), .req_done(req_done),
    .req_cmd_bad(req_cmd_bad), .req_pipe(req_pipe), .sideband_en(sideband_en),
    .req_addr(req_addr), .hi_par(rdq_hi_par_err), .lo_par(rdq_lo_par_err),
    .ev(ev[0]));

  err_xlat_checks #(.XA_W(XA_W)) u_xlat (
    .clk(clk), .rst_n(por_n), .xl_valid(xl_valid), .xl_addr(xl_addr),
    .ap_base(ap_base), .ap_top(ap_top), .vga_en(vga_en), .xl_to_pci(xl_to_pci),
    .mem_top(mem_top), .entry_invalid(xl_entry_invalid), .par_err(xl_par_err),
    .ev(ev[1]));

  generate
    for (genvar p = 0; p < NPATH; p++) begin : g_path
      assign clr_f[p] = (reg_wr && reg_addr == 2'(2*p))     ? reg_wdata : '0;
      assign clr_n[p] = (reg_wr && reg_addr == 2'(2*p + 1)) ? reg_wdata : '0;
      err_tier_log #(.VALID_MASK(path_mask(p))) u_log (
        .clk(clk), .por_n(por_n), .ev(ev[p]), .clr_first(clr_f[p]),
        .clr_next(clr_n[p]), .first_q(first[p]), .next_q(next[p]));
    end
  endgenerate

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_RQ_FIRST: reg_rdata = first[0];
      SEL_RQ_NEXT:  reg_rdata = next[0];
      SEL_XL_FIRST: reg_rdata = first[1];
      SEL_XL_NEXT:  reg_rdata = next[1];
      default:      reg_rdata = '0;
    endcase
  end

  // R10: soft reset alone leaves status untouched
  p_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    (!soft_rst_n && !reg_wr && first[0] != '0) |=> (first[0] != '0));
endmodule

// File: tb/err_status_logger_tb.sv
module err_status_logger_tb;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic por_n, soft_rst_n, req_valid, req_done, req_cmd_bad, req_pipe, sideband_en;
  logic [63:0] req_addr;
  logic rdq_hi_par_err, rdq_lo_par_err, xl_valid, vga_en, xl_to_pci;
  logic [39:0] xl_addr, ap_base, ap_top, mem_top;
  logic xl_entry_invalid, xl_par_err, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  err_status_logger u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle();
    req_valid = 0; req_done = 0; req_cmd_bad = 0; req_pipe = 0; sideband_en = 0;
    req_addr = 0; rdq_hi_par_err = 0; rdq_lo_par_err = 0; xl_valid = 0;
    xl_to_pci = 0; xl_entry_invalid = 0; xl_par_err = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic clear_all();
    for (int a = 0; a < 4; a++) wr(2'(a), 8'hFF);
  endtask

  // drive the stimulus for one request-path bit (no queue growth)
  task automatic set_req_bit(input int b);
    case (b)
      0: begin req_valid = 1; req_done = 1; req_cmd_bad = 1; end
      2: begin req_valid = 1; req_done = 1; req_addr = 64'h1 << 40; end
      3: begin req_valid = 1; req_done = 1; req_pipe = 1; sideband_en = 1; end
      4: rdq_hi_par_err = 1;
      5: rdq_lo_par_err = 1;
      default: ;
    endcase
  endtask

  task automatic fire_req(input int b);
    @(negedge clk); set_req_bit(b);
    @(negedge clk); idle();
  endtask

  task automatic push_req();
    @(negedge clk); req_valid = 1;
    @(negedge clk); idle();
  endtask

  function automatic bit xl_bad(input logic [39:0] a, input bit v, input bit p);
    return (a >= ap_base && a <= ap_top) || (v && a >= 40'hA0000 && a <= 40'hBFFFF)
           || p || (a > mem_top);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] pts [10];
    idle();
    por_n = 0; soft_rst_n = 1; reg_addr = 0; vga_en = 0;
    ap_base = 40'h1000_0000; ap_top = 40'h1FFF_FFFF; mem_top = 40'h4000_0000; xl_addr = 0;
    repeat (4) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rdchk("R11 reset value", 2'(a), 8'h00);

    // R1/R2/R3/R7: sweep ordered pairs of request bits
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        if (i == 1 || j == 1 || i == j) continue;
        fire_req(i);
        rdchk("R1 R7 first latch", 2'd0, 8'(1 << i));
        rdchk("R1 next untouched", 2'd1, 8'h00);
        fire_req(j);
        rdchk("R2 first locked", 2'd0, 8'(1 << i));
        rdchk("R3 next collects", 2'd1, 8'(1 << j));
        fire_req(i);
        rdchk("R3 held bit excluded", 2'd1, 8'(1 << j));
        clear_all();
      end
    end

    // R7: every upper address bit, and the bit below the window
    for (int k = 39; k < 64; k++) begin
      @(negedge clk); req_valid = 1; req_done = 1; req_addr = 64'h1 << k;
      @(negedge clk); idle();
      rdchk("R7 upper address", 2'd0, (k >= 40) ? 8'h04 : 8'h00);
      clear_all();
    end
    // R7: pipelined request without sideband is clean
    @(negedge clk); req_valid = 1; req_done = 1; req_pipe = 1;
    @(negedge clk); idle();
    rdchk("R7 pipe without sideband", 2'd0, 8'h00);

    // R1: simultaneous errors latch together
    @(negedge clk); set_req_bit(0); set_req_bit(4);
    @(negedge clk); idle();
    rdchk("R1 multi first", 2'd0, 8'h11);
    rdchk("R1 multi next", 2'd1, 8'h00);
    // R4: partial write-one-to-clear
    wr(2'd0, 8'h01);
    rdchk("R4 partial clear", 2'd0, 8'h10);
    wr(2'd0, 8'h00);
    rdchk("R4 zero write no effect", 2'd0, 8'h10);
    // R6: reserved bits ignore writes
    wr(2'd0, 8'hC0);
    rdchk("R6 reserved write", 2'd0, 8'h10);
    // R4: clear and recurrence on a held first bit
    @(negedge clk); set_req_bit(4); reg_addr = 0; reg_wr = 1; reg_wdata = 8'h10;
    @(negedge clk); idle();
    rdchk("R4 error wins first", 2'd0, 8'h10);
    fire_req(0);
    rdchk("R3 next bit0", 2'd1, 8'h01);
    @(negedge clk); set_req_bit(0); reg_addr = 1; reg_wr = 1; reg_wdata = 8'h01;
    @(negedge clk); idle();
    rdchk("R4 error wins next", 2'd1, 8'h01);
    wr(2'd1, 8'h01);
    rdchk("R4 next cleared", 2'd1, 8'h00);
    // R5: relatch after clearing first
    wr(2'd0, 8'h10);
    rdchk("R5 first empty", 2'd0, 8'h00);
    fire_req(5);
    rdchk("R5 relatch", 2'd0, 8'h20);
    clear_all();

    // R8: queue depth boundary
    for (int n = 0; n < 16; n++) push_req();
    rdchk("R8 sixteen clean", 2'd0, 8'h00);
    push_req();
    rdchk("R8 overflow", 2'd0, 8'h02);
    clear_all();
    @(negedge clk); req_done = 1;
    @(negedge clk); idle();
    push_req();
    rdchk("R8 retire frees slot", 2'd0, 8'h00);
    push_req();
    rdchk("R8 full again", 2'd0, 8'h02);

    // R10: soft reset keeps status, empties counter
    @(negedge clk); soft_rst_n = 0;
    @(negedge clk); soft_rst_n = 1;
    rdchk("R10 sticky across soft reset", 2'd0, 8'h02);
    clear_all();
    for (int n = 0; n < 16; n++) push_req();
    rdchk("R10 counter emptied", 2'd0, 8'h00);

    // R9: translated address grid
    pts[0] = 40'h9_FFFF;      pts[1] = 40'hA_0000;      pts[2] = 40'hB_FFFF;
    pts[3] = 40'hC_0000;      pts[4] = 40'h0FFF_FFFF;   pts[5] = 40'h1000_0000;
    pts[6] = 40'h1FFF_FFFF;   pts[7] = 40'h2000_0000;   pts[8] = 40'h4000_0000;
    pts[9] = 40'h4000_0001;
    for (int v = 0; v < 2; v++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 10; k++) begin
          @(negedge clk); vga_en = v[0]; xl_to_pci = p[0]; xl_valid = 1; xl_addr = pts[k];
          @(negedge clk); idle();
          rdchk("R9 illegal address", 2'd2,
                xl_bad(pts[k], v[0], p[0]) ? 8'h02 : 8'h00);
          rdchk("R9 xl next quiet", 2'd3, 8'h00);
          clear_all();
        end
      end
    end
    vga_en = 0;
    @(negedge clk); xl_to_pci = 1;
    @(negedge clk); idle();
    rdchk("R9 no flag without valid", 2'd2, 8'h00);
    @(negedge clk); xl_entry_invalid = 1;
    @(negedge clk); idle();
    rdchk("R9 entry invalid", 2'd2, 8'h04);
    @(negedge clk); xl_par_err = 1;
    @(negedge clk); idle();
    rdchk("R9 parity to next", 2'd3, 8'h08);
    rdchk("R11 paths separate", 2'd0, 8'h00);
    wr(2'd2, 8'hF1);
    rdchk("R6 xl reserved", 2'd2, 8'h04);

    // R10: power-on reset clears status
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    rdchk("R10 por clears first", 2'd2, 8'h00);
    rdchk("R10 por clears next", 2'd3, 8'h00);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule